// File: doc/BRIEF.md
# Self-Correcting Divide-by-Eight Johnson Counter

This block is a four-stage twisted-ring counter that walks through eight states and repeats. Each state drives exactly one of eight active-high decoded outputs. An active-low carry flag reflects the top stage of the ring. Because only one stage changes per step, every decoded output is built from two neighbouring stages and never sees a transient double-change.

Two count inputs control stepping. `cp_up` counts on its rising edge while `cp_dn` is low. `cp_dn` counts on its falling edge while `cp_up` is high. Either input can therefore act as the clock while the other gates it. The carry flag goes high again when the ring wraps from state 7 to state 0. Fed to `cp_up` of a second counter, it steps that counter once per eight counts.

Everything runs on a free-running system clock `clk`. Both count inputs pass through two-flop synchronizers, and an edge is found by comparing each synchronized value with its previous sample. The master reset `mreset` clears the ring at once, without waiting for a clock, and its release is synchronized. A modified feedback term pulls every illegal 4-bit code back into the legal ring. A test preload port can force any code into the ring.

Top module: `johnson_div8`

## Requirements
- R1: The ring stages (q3..q0) follow 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and then repeat. These are states 0 to 7.
- R2: `dec[n]` is high, and every other `dec` bit is low, exactly when the ring is in legal state n.
- R3: A rising edge of `cp_up` while `cp_dn` is low advances the ring by one state. The new state appears on `dec` within four `clk` cycles after the edge.
- R4: A falling edge of `cp_dn` while `cp_up` is high advances the ring by one state. No other input activity changes the state. This includes a rising `cp_up` while `cp_dn` is high, a falling `cp_dn` while `cp_up` is low, a falling `cp_up` and a rising `cp_dn`.
- R5: `carry_n` is low in states 4 to 7 and high in states 0 to 3.
- R6: `carry_n` makes exactly one low-to-high transition per eight advances, at the step from state 7 to state 0, so it can drive `cp_up` of a following counter.
- R7: While `mreset` is high the ring is state 0 (`dec` = 8'h01, `carry_n` = 1), without waiting for a `clk` edge. Count edges during reset are not counted.
- R8: From any of the eight illegal codes, the ring reaches a legal state within 11 advances and then follows the legal sequence.
- R9: Each advance from a legal state changes exactly one ring stage, so `dec` never shows more than one active bit.
- R10: When `load_en` is high at a `clk` edge, `load_code` is written into the ring (bit 3 = q3). This takes priority over an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| mreset | input | 1 | Asynchronous master reset, active high |
| cp_up | input | 1 | Count input, counts on rising edge while cp_dn is low |
| cp_dn | input | 1 | Count input, counts on falling edge while cp_up is high |
| load_en | input | 1 | Test preload strobe |
| load_code | input | 4 | Test preload code, q3..q0 |
| dec | output | 8 | One-hot decoded state, active high |
| carry_n | output | 1 | Active-low flag for states 4 to 7 |

## Verification
The embedded assertions check several properties on every cycle. They check that a legal ring gives a one-hot decode and a matching carry level, and that a legal ring stays legal. They check that each qualified advance moves exactly one stage, that the state holds when no advance or load arrives, and that reset holds state 0. Other behaviour needs the bench's scenarios. These are: the full ordering of the sequence under both count inputs, the rejection of each wrongly-qualified edge, the carry wrap, and recovery from every illegal code within the 11-advance limit.

// File: rtl/johnson_div8.sv
module johnson_div8 (
  input  logic       clk,
  input  logic       mreset,
  input  logic       cp_up,
  input  logic       cp_dn,
  input  logic       load_en,
  input  logic [3:0] load_code,
  output logic [7:0] dec,
  output logic       carry_n
);

  logic [1:0] rsync;
  logic       rst_i;

  always_ff @(posedge clk or posedge mreset)
    if (mreset) rsync <= 2'b11;
    else        rsync <= {rsync[0], 1'b0};

  assign rst_i = rsync[1];

  logic [2:0] up_sh, dn_sh;

  always_ff @(posedge clk) begin
    up_sh <= {up_sh[1:0], cp_up};
    dn_sh <= {dn_sh[1:0], cp_dn};
  end

  logic up_now, up_old, dn_now, dn_old, adv;
  assign up_now = up_sh[1];
  assign up_old = up_sh[2];
  assign dn_now = dn_sh[1];
  assign dn_old = dn_sh[2];

  assign adv = (up_now & ~up_old & ~dn_now) | (dn_old & ~dn_now & up_now);

  logic [3:0] q, nxt;

  assign nxt = {q[2], q[1], q[0], ~q[3] & ~(q[2] & ~q[1])};

  always_ff @(posedge clk or posedge rst_i)
    if (rst_i)        q <= 4'h0;
    else if (load_en) q <= load_code;
    else if (adv)     q <= nxt;

  assign dec[0]  = ~q[3] & ~q[0];
  assign dec[1]  =  q[0] & ~q[1];
  assign dec[2]  =  q[1] & ~q[2];
  assign dec[3]  =  q[2] & ~q[3];
  assign dec[4]  =  q[3] &  q[0];
  assign dec[5]  =  q[1] & ~q[0];
  assign dec[6]  =  q[2] & ~q[1];
  assign dec[7]  =  q[3] & ~q[2];
  assign carry_n = ~q[3];

  logic legal;
  assign legal = q inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8};

  AST_LEGAL_ONEHOT: assert property (@(posedge clk) disable iff (rst_i)
    legal |-> $onehot(dec)); // R2

  AST_CARRY_LEVEL: assert property (@(posedge clk) disable iff (rst_i)
    legal |-> (carry_n == (dec[7:4] == 4'h0))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst_i)
    (!adv && !load_en) |=> $stable(q)); // R4

  AST_ONE_STAGE_STEP: assert property (@(posedge clk) disable iff (rst_i)
    (legal && adv && !load_en) |=> ($countones(q ^ $past(q)) == 1)); // R9

  AST_STAYS_LEGAL: assert property (@(posedge clk) disable iff (rst_i)
    (legal && !load_en) |=> legal); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst_i)
    load_en |=> (q == $past(load_code))); // R10

  always @(negedge clk)
    if (rst_i) AST_RESET_ZERO: assert (dec == 8'h01 && carry_n); // R7

endmodule

// File: tb/test_johnson_div8.sv
module test_johnson_div8;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       mreset = 1'b0;
  logic       cp_up = 1'b0;
  logic       cp_dn = 1'b0;
  logic       load_en = 1'b0;
  logic [3:0] load_code = 4'h0;
  logic [7:0] dec;
  logic       carry_n;

  int checks = 0;
  int errors = 0;

  johnson_div8 i_johnson_div8 (
    .clk(clk), .mreset(mreset), .cp_up(cp_up), .cp_dn(cp_dn),
    .load_en(load_en), .load_code(load_code), .dec(dec), .carry_n(carry_n)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_up(logic v);
    @(negedge clk); cp_up = v; settle();
  endtask

  task automatic set_dn(logic v);
    @(negedge clk); cp_dn = v; settle();
  endtask

  task automatic step_up();
    set_up(1'b1); set_up(1'b0);
  endtask

  function automatic logic [7:0] onehot(int n);
    return 8'd1 << (n % 8);
  endfunction

  function automatic int hot_index(logic [7:0] d);
    for (int i = 0; i < 8; i++) if (d[i]) return i;
    return -1;
  endfunction

  task automatic load(logic [3:0] c);
    @(negedge clk); load_en = 1'b1; load_code = c;
    @(negedge clk); load_en = 1'b0;
  endtask

  int state;
  logic prev_carry;
  int rises;

  initial begin
    #1 mreset = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 reset dec", dec, 8'h01);
    chk("R7 reset carry", {7'd0, carry_n}, 8'd1);
    mreset = 1'b0;
    settle();

    // R1 R2 R3 R5 R6: rising cp_up sweep
    state = 0; rises = 0; prev_carry = carry_n;
    for (int k = 1; k <= 16; k++) begin
      step_up();
      state = k % 8;
      chk("R3 R1 R2 up-step dec", dec, onehot(state));
      chk("R5 carry level", {7'd0, carry_n}, {7'd0, state < 4});
      if (!prev_carry && carry_n) begin
        rises++;
        chk("R6 carry rise at wrap", state[7:0], 8'd0);
      end
      prev_carry = carry_n;
    end
    chk("R6 carry rises per 16 steps", rises[7:0], 8'd2);

    // R4: cp_dn falling while cp_up high
    set_up(1'b1);
    chk("R4 cp_up rise while cp_dn low advances", dec, onehot(1));
    state = 1;
    for (int k = 0; k < 8; k++) begin
      set_dn(1'b1);
      chk("R4 cp_dn rise holds", dec, onehot(state));
      set_dn(1'b0);
      state = (state + 1) % 8;
      chk("R4 cp_dn fall advances", dec, onehot(state));
    end

    // R4: holds
    set_dn(1'b1);
    set_up(1'b0);
    chk("R4 cp_up fall holds", dec, onehot(state));
    set_up(1'b1);
    chk("R4 cp_up rise with cp_dn high holds", dec, onehot(state));
    set_up(1'b0);
    set_dn(1'b0);
    chk("R4 cp_dn fall with cp_up low holds", dec, onehot(state));

    // R9: single active output on every cycle of a sweep
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); cp_up = 1'b1;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (c == 3) cp_up = 1'b0;
        checks++;
        if ($countones(dec) != 1) begin
          errors++;
          $display("FAIL R9: got %0d active outputs expected 1", $countones(dec));
        end
      end
    end
    state = (state + 8) % 8;

    // R7: async reset mid-cycle, edges ignored during reset
    step_up(); step_up();
    state = (state + 2) % 8;
    chk("R7 pre-reset state", dec, onehot(state));
    @(posedge clk); #2 mreset = 1'b1; #1;
    chk("R7 async clear before clock", dec, 8'h01);
    step_up(); step_up();
    chk("R7 edges ignored in reset", dec, 8'h01);
    @(negedge clk); mreset = 1'b0;
    settle();
    chk("R7 state after release", dec, 8'h01);

    // R10: preload of every legal code
    for (int n = 0; n < 8; n++) begin
      logic [3:0] code;
      code = (n < 4) ? 4'((1 << n) - 1) : 4'((4'hF << (n - 4)) & 4'hF);
      load(code);
      chk("R10 preload legal code", dec, onehot(n));
    end

    // R8: recovery from each illegal code
    for (int c = 0; c < 16; c++) begin
      logic [3:0] code;
      int steps;
      int idx;
      code = 4'(c);
      if (code inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8}) continue;
      load(code);
      steps = 0;
      while ($countones(dec) != 1 && steps < 12) begin
        step_up();
        steps++;
      end
      checks++;
      if (steps > 11 || $countones(dec) != 1) begin
        errors++;
        $display("FAIL R8: code %h took %0d advances expected <= 11", code, steps);
      end
      idx = hot_index(dec);
      for (int k = 1; k <= 8; k++) begin
        step_up();
        chk("R8 legal sequence after recovery", dec, onehot(idx + k));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule